// File: doc/BRIEF.md
# Gray-code quasi-random sequence generator

This block produces one dimension of a low-discrepancy integer sequence. A table of 32 direction words, 32 bits each, is filled through a simple write port. The value of point n is the XOR of every direction word whose bit position is set in the Gray code of n. The block can place itself at any index by computing that value directly. From there it walks the sequence one index at a time, or by a fixed stride of 2^p indices on each step.

The strided walk needs only two table reads and two XORs on each step. Several instances can therefore be started at neighbouring indices with the same stride. Each one then emits an evenly spaced subsequence, and the lanes interleave into the plain sequence. A start request loads the index and the stride exponent. The result appears after a short iterative computation. After that, each step request advances the point by one stride until the 32-bit index would wrap.

Top module: `qrs_gen`

## Requirements
- R1: After reset, point_o is 0, valid_o is 0 and ovf_o is 0, and all direction words are 0.
- R2: A write with dir_we_i high stores dir_data_i at table address dir_addr_i (0 to 31). Address a is the word applied for Gray-code bit a. The write takes effect at the clock edge where it is sampled.
- R3: A start with index n sets point_o to the XOR of the words at every address a where bit a of n ^ (n >> 1) is 1. Let L be one plus the position of the highest set Gray bit, or 0 when n is 0. Then valid_o is low from the edge that samples start_i and rises at the (L+1)-th edge after it.
- R4: With stride exponent 0, each step accepted while valid_o is high moves the index from n to n+1, and point_o becomes the value that R3 gives for n+1.
- R5: The stride exponent p (0 to 31) is captured at start. Each accepted step moves the index by 2^p, and point_o becomes the R3 value of the new index. Changes on stride_exp_i between starts have no effect.
- R6: A step requested while valid_o is low is ignored. The result of the pending start is unchanged by it.
- R7: A step that would carry the index past 2^32-1 sets ovf_o and leaves point_o unchanged. While ovf_o is high, steps are ignored. A start clears ovf_o.
- R8: When start_i and step_i are high in the same cycle, the start is taken and the step is dropped.
- R9: When a step and a direction write are sampled at the same edge, the step uses the table contents from before the write. Later steps and starts use the new word.
- R10: For stride exponent p, 2^p lanes started at indices b+i (i = 0 to 2^p-1) together produce the plain sequential sequence from index b. Their j-th outputs are interleaved as entry i + j*2^p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_we_i | input | 1 | Direction-word write enable |
| dir_addr_i | input | 5 | Direction-word address, equal to the Gray bit position it serves |
| dir_data_i | input | 32 | Direction-word data |
| start_i | input | 1 | Start request: load index and stride, compute point directly |
| start_idx_i | input | 32 | Index to start from |
| stride_exp_i | input | 5 | Stride exponent p, captured at start |
| step_i | input | 1 | Advance by one stride |
| point_o | output | 32 | Current point |
| valid_o | output | 1 | Point is current and steps are accepted |
| ovf_o | output | 1 | Index would have wrapped; steps blocked |

## Verification
Two pairs of functions can meet in one cycle. A start can coincide with a step, and a step can coincide with a direction write. The bench raises start and step together while the point is valid, and expects the point for the new start index with no trace of the step. It also raises a step together with a write to the table word that this very step consumes. It then expects the step result from the old word, and a following step to use the new word. A cycle-accurate behavioural model, which recomputes every point from the Gray-code formula, is compared against the outputs on every clock. This comparison also catches steps leaking into the direct computation and steps leaking past the overflow state.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int unsigned QRS_WIDTH = 32;

  typedef enum logic [1:0] {
    RUN_IDLE,
    RUN_CALC,
    RUN_LIVE,
    RUN_HALT
  } run_state_e;
endpackage

// File: rtl/qrs_dir_table.sv
module qrs_dir_table #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o,
  input  logic [AW-1:0]    raddr_c_i,
  output logic [WIDTH-1:0] rdata_c_o
);
  logic [WIDTH-1:0] words_q [WIDTH];

  for (genvar g = 0; g < WIDTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          words_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   words_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = words_q[raddr_a_i];
  assign rdata_b_o = words_q[raddr_b_i];
  assign rdata_c_o = words_q[raddr_c_i];

  // R2: a sampled write is visible at its address on the next cycle
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> words_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/qrs_lowzero.sv
module qrs_lowzero #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic [AW-1:0]    pos_o,
  output logic             found_o
);
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!vec_i[i]) begin
        found_o = 1'b1;
        pos_o   = AW'(i);
      end
    end
  end

  always_comb begin
    if (found_o) begin
      p_zero_pos_r5: assert (!vec_i[pos_o]);
      p_below_ones_r5: assert ((vec_i & ((WIDTH'(1) << pos_o) - WIDTH'(1)))
                               == ((WIDTH'(1) << pos_o) - WIDTH'(1)));
    end
  end
endmodule

// File: rtl/qrs_direct.sv
module qrs_direct #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] idx_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [AW-1:0]    addr_o,
  output logic             done_o,
  output logic [WIDTH-1:0] acc_o
);
  logic [WIDTH-1:0] gray_q;
  logic [WIDTH-1:0] acc_q;
  logic [AW-1:0]    addr_q;
  logic             busy_q;

  // one Gray bit per cycle, stop as soon as no set bits remain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gray_q <= '0;
      acc_q  <= '0;
      addr_q <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      gray_q <= idx_i ^ (idx_i >> 1);
      acc_q  <= '0;
      addr_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (gray_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        if (gray_q[0]) acc_q <= acc_q ^ word_i;
        gray_q <= gray_q >> 1;
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign addr_o = addr_q;
  assign acc_o  = acc_q;
  assign done_o = busy_q && (gray_q == '0);

  // R3: a load always begins a computation
  p_load_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_q);
endmodule

// File: rtl/qrs_gen.sv
module qrs_gen
  import qrs_pkg::*;
#(
  parameter int unsigned WIDTH = QRS_WIDTH,
  localparam int unsigned AW = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_we_i,
  input  logic [AW-1:0]    dir_addr_i,
  input  logic [WIDTH-1:0] dir_data_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] start_idx_i,
  input  logic [AW-1:0]    stride_exp_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] point_o,
  output logic             valid_o,
  output logic             ovf_o
);
  run_state_e       state_q;
  logic [WIDTH-1:0] idx_q, point_q;
  logic [AW-1:0]    pexp_q;

  logic [WIDTH-1:0] stride_one, stride_mask, word_p_raw, stride_word, word_c;
  logic [WIDTH-1:0] eng_word, eng_acc;
  logic [AW-1:0]    eng_addr, zero_pos, p_addr;
  logic             eng_done, zero_found;

  assign stride_one  = WIDTH'(1) << pexp_q;
  assign stride_mask = stride_one - WIDTH'(1);
  assign p_addr      = pexp_q - AW'(1);
  assign stride_word = (pexp_q == '0) ? '0 : word_p_raw;

  qrs_dir_table #(.WIDTH(WIDTH)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (dir_we_i),
    .waddr_i   (dir_addr_i),
    .wdata_i   (dir_data_i),
    .raddr_a_i (eng_addr),
    .rdata_a_o (eng_word),
    .raddr_b_i (p_addr),
    .rdata_b_o (word_p_raw),
    .raddr_c_i (zero_pos),
    .rdata_c_o (word_c)
  );

  // carry end of idx + 2^p: first zero at or above bit p
  qrs_lowzero #(.WIDTH(WIDTH)) i_lowzero (
    .vec_i   (idx_q | stride_mask),
    .pos_o   (zero_pos),
    .found_o (zero_found)
  );

  qrs_direct #(.WIDTH(WIDTH)) i_direct (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .idx_i  (start_idx_i),
    .word_i (eng_word),
    .addr_o (eng_addr),
    .done_o (eng_done),
    .acc_o  (eng_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
      idx_q   <= '0;
      pexp_q  <= '0;
      point_q <= '0;
    end else if (start_i) begin
      state_q <= RUN_CALC;
      idx_q   <= start_idx_i;
      pexp_q  <= stride_exp_i;
    end else begin
      unique case (state_q)
        RUN_CALC: begin
          if (eng_done) begin
            point_q <= eng_acc;
            state_q <= RUN_LIVE;
          end
        end
        RUN_LIVE: begin
          if (step_i) begin
            if (!zero_found) begin
              state_q <= RUN_HALT;
            end else begin
              point_q <= point_q ^ stride_word ^ word_c;
              idx_q   <= idx_q + stride_one;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign point_o = point_q;
  assign valid_o = (state_q == RUN_LIVE) || (state_q == RUN_HALT);
  assign ovf_o   = (state_q == RUN_HALT);

  p_start_drops_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);
  p_start_clears_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ovf_o);
  p_halt_freezes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !start_i) |=> (ovf_o && $stable(point_o)));
  p_calc_ignores_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !eng_done && !start_i) |=> (!valid_o && $stable(point_o)));
  p_result_on_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && !start_i) |=> (valid_o && point_o == $past(eng_acc)));
  p_valid_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> valid_o);
endmodule

// File: tb/test_qrs_gen.sv
module test_qrs_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic        start = 1'b0;
  logic [31:0] sidx = '0;
  logic [4:0]  sexp = '0;
  logic        step = 1'b0;
  logic [31:0] point;
  logic        valid, ovf;

  int n_chk = 0;
  int n_err = 0;
  int wd = 0;

  qrs_gen i_qrs_gen (
    .clk_i(clk), .rst_ni(rst_n), .dir_we_i(we), .dir_addr_i(waddr),
    .dir_data_i(wdata), .start_i(start), .start_idx_i(sidx),
    .stride_exp_i(sexp), .step_i(step), .point_o(point),
    .valid_o(valid), .ovf_o(ovf)
  );

  always #2 clk = ~clk;

  // behavioural reference
  logic [31:0] m_dir [32];
  logic [31:0] m_point, m_pend, m_idx;
  longint      m_nx;
  int          m_p, m_cnt;
  bit          m_calc, m_valid, m_ovf;

  function automatic logic [31:0] ref_point(logic [31:0] n);
    logic [31:0] g, acc;
    g = n ^ (n >> 1);
    acc = '0;
    for (int k = 0; k < 32; k++) if (g[k]) acc = acc ^ m_dir[k];
    return acc;
  endfunction

  function automatic int ref_lat(logic [31:0] n);
    logic [31:0] g;
    int l;
    g = n ^ (n >> 1);
    l = 0;
    for (int k = 0; k < 32; k++) if (g[k]) l = k + 1;
    return l + 1;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 32; k++) m_dir[k] = '0;
      m_point = '0; m_pend = '0; m_idx = '0;
      m_p = 0; m_cnt = 0; m_calc = 0; m_valid = 0; m_ovf = 0;
    end else if (start) begin
      if (we) m_dir[waddr] = wdata;
      m_idx = sidx; m_p = int'(sexp);
      m_pend = ref_point(sidx); m_cnt = ref_lat(sidx);
      m_calc = 1; m_valid = 0; m_ovf = 0;
    end else begin
      if (m_calc) begin
        m_cnt--;
        if (m_cnt == 0) begin m_calc = 0; m_valid = 1; m_point = m_pend; end
      end else if (m_valid && !m_ovf && step) begin
        m_nx = longint'(m_idx) + (longint'(1) << m_p);
        if (m_nx > longint'(32'hFFFF_FFFF)) m_ovf = 1;
        else begin m_idx = 32'(m_nx); m_point = ref_point(m_idx); end
      end
      if (we) m_dir[waddr] = wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(valid == m_valid, "R3 valid", 32'(valid), 32'(m_valid));
      chk(ovf == m_ovf, "R7 overflow flag", 32'(ovf), 32'(m_ovf));
      chk(point == m_point, "R4 point", point, m_point);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    we = 1'b1; waddr = 5'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic go(logic [31:0] n, int p, output int cyc);
    start = 1'b1; sidx = n; sexp = 5'(p);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!valid) begin @(negedge clk); cyc++; end
  endtask

  task automatic stp();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  initial begin
    int cyc;
    int nl, np;
    logic [31:0] exp_v, base;
    logic [31:0] seq [64];
    logic [31:0] lan [64];

    repeat (3) @(negedge clk);
    chk(point == 0 && !valid && !ovf, "R1 reset state", point, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 32; k++) wr(k, (32'h9E37_79B9 * 32'(k + 1)) ^ (32'h1 << k));

    go(32'd0, 0, cyc);
    chk(cyc == 2, "R3 latency index 0", 32'(cyc), 32'd2);
    chk(point == 0, "R3 point at index 0", point, 32'd0);

    go(32'h0000_1234, 0, cyc);
    chk(cyc == ref_lat(32'h1234) + 1, "R3 latency", 32'(cyc), 32'(ref_lat(32'h1234) + 1));
    chk(point == ref_point(32'h1234), "R2 direct point", point, ref_point(32'h1234));

    for (int j = 0; j < 10; j++) stp();
    chk(point == ref_point(32'h123E), "R4 sequential steps", point, ref_point(32'h123E));

    // R6: steps while computing are ignored
    start = 1'b1; sidx = 32'hFFFF_FFFF; sexp = 5'd0;
    @(negedge clk);
    start = 1'b0; step = 1'b1;
    repeat (5) @(negedge clk);
    step = 1'b0;
    while (!valid) @(negedge clk);
    chk(point == ref_point(32'hFFFF_FFFF), "R6 step during compute", point, ref_point(32'hFFFF_FFFF));

    go(32'hFFFF_FFFF, 0, cyc);
    chk(cyc == 34, "R3 latency full index", 32'(cyc), 32'd34);
    stp();
    chk(ovf == 1'b1, "R7 overflow set", 32'(ovf), 32'd1);
    chk(point == ref_point(32'hFFFF_FFFF), "R7 point held", point, ref_point(32'hFFFF_FFFF));
    stp();
    chk(ovf && point == ref_point(32'hFFFF_FFFF), "R7 step blocked", point, ref_point(32'hFFFF_FFFF));
    go(32'd7, 0, cyc);
    chk(!ovf, "R7 start clears overflow", 32'(ovf), 32'd0);

    go(32'd40, 3, cyc);
    sexp = 5'd1;
    repeat (4) stp();
    chk(point == ref_point(32'd72), "R5 stride latched", point, ref_point(32'd72));

    go(32'd5, 31, cyc);
    stp();
    chk(point == ref_point(32'h8000_0005), "R5 stride 2^31", point, ref_point(32'h8000_0005));
    stp();
    chk(ovf == 1'b1, "R7 overflow at stride 2^31", 32'(ovf), 32'd1);

    go(32'd100, 0, cyc);
    start = 1'b1; sidx = 32'd500; sexp = 5'd0; step = 1'b1;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    while (!valid) @(negedge clk);
    chk(point == ref_point(32'd500), "R8 start wins over step", point, ref_point(32'd500));

    // R9: index 11 steps through word 2 while it is rewritten
    go(32'd11, 0, cyc);
    exp_v = ref_point(32'd12);
    we = 1'b1; waddr = 5'd2; wdata = 32'hDEAD_BEEF; step = 1'b1;
    @(negedge clk);
    we = 1'b0; step = 1'b0;
    chk(point == exp_v, "R9 step uses old word", point, exp_v);
    go(32'd4, 0, cyc);
    chk(point == ref_point(32'd4), "R9 new word used later", point, ref_point(32'd4));

    for (int pp = 2; pp <= 3; pp++) begin
      nl = 1 << pp;
      np = 64 / nl;
      base = 32'h0000_03F0 + 32'(pp * 7);
      go(base, 0, cyc);
      seq[0] = point;
      for (int j = 1; j < 64; j++) begin stp(); seq[j] = point; end
      for (int l = 0; l < nl; l++) begin
        go(base + 32'(l), pp, cyc);
        lan[l] = point;
        for (int j = 1; j < np; j++) begin stp(); lan[l + j * nl] = point; end
      end
      for (int j = 0; j < 64; j++) chk(lan[j] == seq[j], "R10 lane interleave", lan[j], seq[j]);
    end

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule